// File: doc/BRIEF.md
# Page Table Walk Address Assist Register File

This block is a small set of special registers that shortens the software routine run after a translation miss. When a miss occurs, the block captures the faulting page number. Software then reads the first-level descriptor address and the page table entry address straight out of two registers, without doing any shift-and-mask arithmetic itself. The block holds a first-level table base and a second-level table base. On a read, each base is merged with index bits cut from the held data-side page number.

A scratch register lets the routine park a working register while it walks the tables. Access goes through a plain register bus: a write strobe, a read strobe, a 10-bit register number and 32-bit data. Read data is registered and appears one cycle after the read strobe. The memory fetches of the walk and the translation buffer itself are outside this block.

Top module: `twa_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every stored register clears to zero and `reg_rdata` is zero after that edge.
- R2: A read strobe at a clock edge puts the selected register's read value on `reg_rdata` after that edge. Without a read strobe, `reg_rdata` keeps its value.
- R3: Register 787 (instruction-side page) and register 795 (data-side page) store only bits 31:12 (page number), bit 9 (valid) and bits 3:0 (space id) of a write. All other bits read as zero.
- R4: A pulse on `imiss_valid` or `dmiss_valid` loads its page number into bits 31:12 of register 787 or 795 and leaves the low bits unchanged. A software write to that same register in the same cycle is dropped.
- R5: Register 796 stores bits 31:12 of a write as the first-level base. A read returns that base in bits 31:12, bits 19:10 of the held data-side page in bits 11:2, and zero in bits 1:0.
- R6: Register 797 stores bits 31:12 (second-level base) and bits 8:0 of a write. With `walk_4k_mode` high, a read returns the base in bits 31:12, bits 9:0 of the held data-side page in bits 11:2, and zero in bits 1:0.
- R7: With `walk_4k_mode` low, a read of register 797 returns the stored value, with bits 11:9 reading zero.
- R8: Register 799 stores and returns all 32 bits.
- R9: A read of any other register number returns zero. A write to any other number changes no stored register.
- R10: When a read and a write to the same register coincide, the read returns the value held before the write.
- R11: The computed reads of 796 and 797 follow the data-side page held at the time of the read, including a page loaded by a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_num | input | 10 | Special register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| walk_4k_mode | input | 1 | Selects small-page assist for the entry address |
| imiss_valid | input | 1 | Instruction-side miss capture strobe |
| imiss_page | input | 20 | Instruction-side faulting page number |
| dmiss_valid | input | 1 | Data-side miss capture strobe |
| dmiss_page | input | 20 | Data-side faulting page number |

## Verification
A wrong held page number never shows up alone. It corrupts the next read of 795 and also the index fields of the very next 796 and 797 reads, one cycle after each read strobe. The bench therefore reads all three after every miss. A decode fault shows as data from the wrong register, or as non-zero data on an unused number, on the cycle after the read. A fault in a write mask or in the miss priority shows only when the register is read back, so every write is followed by a read of the same register and of its neighbours.

// File: rtl/twa_pkg.sv
// Shared widths, field masks and register index order for the walk assist file.
// Assumes a 32-bit register bus and 4 KiB base pages.
package twa_pkg;
    localparam int DATA_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = DATA_W - PAGE_LSB;   // page number width
    localparam int IDX_W    = PAGE_LSB - 2;        // word index width

    // bit-enable masks for stored fields
    localparam logic [DATA_W-1:0] PAGE_WMASK  = {{PAGE_W{1'b1}}, 12'h20F};
    localparam logic [DATA_W-1:0] BASE_WMASK  = {{PAGE_W{1'b1}}, 12'h000};
    localparam logic [DATA_W-1:0] CTRL_WMASK  = {{PAGE_W{1'b1}}, 12'h1FF};

    // register slot order inside the file
    localparam int NREG     = 5;
    localparam int SLOT_IPG = 0;
    localparam int SLOT_DPG = 1;
    localparam int SLOT_L1B = 2;
    localparam int SLOT_CTL = 3;
    localparam int SLOT_SCR = 4;

    typedef logic [NREG-1:0] slot_sel_t;
endpackage

// File: rtl/twa_decode.sv
// Register number decoder: turns a bus register number into a one-hot slot select.
// Assumes all numbers in NUM_VEC are distinct, so at most one slot matches.
module twa_decode
    import twa_pkg::*;
#(
    parameter int REGNUM_W = 10,
    parameter logic [NREG*REGNUM_W-1:0] NUM_VEC = '0
) (
    input  logic [REGNUM_W-1:0] reg_num,
    output slot_sel_t           sel,
    output logic                hit
);
    // one comparator per implemented slot
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign sel[g] = (reg_num == NUM_VEC[g*REGNUM_W +: REGNUM_W]);
    end

    // any slot matched
    assign hit = |sel;
endmodule

// File: rtl/twa_store.sv
// Storage for the five registers: masked software writes and miss capture.
// Assumes sel is one-hot or zero; miss capture wins over a write to the same page register.
module twa_store
    import twa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  slot_sel_t         sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              imiss_valid,
    input  logic [PAGE_W-1:0] imiss_page,
    input  logic              dmiss_valid,
    input  logic [PAGE_W-1:0] dmiss_page,
    output logic [NREG-1:0][DATA_W-1:0] q
);
    localparam logic [NREG-1:0][DATA_W-1:0] WMASK =
        {{DATA_W{1'b1}}, CTRL_WMASK, BASE_WMASK, PAGE_WMASK, PAGE_WMASK};

    logic [NREG-1:0] miss_hit;
    logic [NREG-1:0][PAGE_W-1:0] miss_pg;

    // map the two miss ports onto their page slots
    always_comb begin
        miss_hit = '0;
        miss_pg  = '0;
        miss_hit[SLOT_IPG] = imiss_valid;
        miss_pg[SLOT_IPG]  = imiss_page;
        miss_hit[SLOT_DPG] = dmiss_valid;
        miss_pg[SLOT_DPG]  = dmiss_page;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // per-slot register: reset, miss capture, then masked write
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (miss_hit[g])
                q[g] <= {miss_pg[g], q[g][PAGE_LSB-1:0]};
            else if (we && sel[g])
                q[g] <= wdata & WMASK[g];
        end
    end
endmodule

// File: rtl/twa_addr_calc.sv
// Walk address arithmetic: merges stored bases with index fields of the data-side page.
// Assumes two-level tables with word-sized descriptors and a 10/10 page number split.
module twa_addr_calc
    import twa_pkg::*;
(
    input  logic              mode_4k,
    input  logic [DATA_W-1:0] l1_base_q,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [PAGE_W-1:0] dpage,
    output logic [DATA_W-1:0] l1_addr,
    output logic [DATA_W-1:0] ctrl_rd
);
    logic [IDX_W-1:0] l1_idx;
    logic [IDX_W-1:0] l2_idx;

    // upper and lower index fields of the held page
    assign l1_idx = dpage[PAGE_W-1 -: IDX_W];
    assign l2_idx = dpage[IDX_W-1:0];

    // first-level descriptor address
    assign l1_addr = {l1_base_q[DATA_W-1:PAGE_LSB], l1_idx, 2'b00};

    // entry address in small-page assist mode, raw contents otherwise
    always_comb begin
        if (mode_4k)
            ctrl_rd = {ctrl_q[DATA_W-1:PAGE_LSB], l2_idx, 2'b00};
        else
            ctrl_rd = ctrl_q;
    end
endmodule

// File: rtl/twa_rdmux.sv
// Read-out path: AND-OR selects one slot view and registers it on a read strobe.
// Assumes sel is one-hot or zero; a zero select yields zero data.
module twa_rdmux
    import twa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  slot_sel_t         sel,
    input  logic [NREG-1:0][DATA_W-1:0] view,
    output logic [DATA_W-1:0] rdata
);
    logic [NREG-1:0][DATA_W-1:0] gated;
    logic [DATA_W-1:0]           merged;

    for (genvar g = 0; g < NREG; g++) begin : g_gate
        assign gated[g] = view[g] & {DATA_W{sel[g]}};
    end

    // OR-reduce the gated views
    always_comb begin
        merged = '0;
        for (int i = 0; i < NREG; i++) merged = merged | gated[i];
    end

    // capture on read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= merged;
    end
endmodule

// File: rtl/twa_regfile.sv
// Top of the walk assist register file: decode, storage, address arithmetic, read-out.
// Assumes the register numbers given as parameters are distinct and fit REGNUM_W bits.
module twa_regfile
    import twa_pkg::*;
#(
    parameter int REGNUM_W = 10,
    parameter int NUM_IPG  = 787,
    parameter int NUM_DPG  = 795,
    parameter int NUM_L1B  = 796,
    parameter int NUM_CTL  = 797,
    parameter int NUM_SCR  = 799
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic [REGNUM_W-1:0] reg_num,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                walk_4k_mode,
    input  logic                imiss_valid,
    input  logic [19:0]         imiss_page,
    input  logic                dmiss_valid,
    input  logic [19:0]         dmiss_page
);
    localparam logic [NREG*REGNUM_W-1:0] NUM_VEC = {
        REGNUM_W'(NUM_SCR), REGNUM_W'(NUM_CTL), REGNUM_W'(NUM_L1B),
        REGNUM_W'(NUM_DPG), REGNUM_W'(NUM_IPG)};

    slot_sel_t                   sel;
    logic                        hit;
    logic [NREG-1:0][DATA_W-1:0] q;
    logic [NREG-1:0][DATA_W-1:0] view;
    logic [DATA_W-1:0]           l1_addr;
    logic [DATA_W-1:0]           ctrl_rd;

    twa_decode #(.REGNUM_W(REGNUM_W), .NUM_VEC(NUM_VEC)) u_dec (
        .reg_num (reg_num),
        .sel     (sel),
        .hit     (hit)
    );

    twa_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we & hit),
        .sel         (sel),
        .wdata       (reg_wdata),
        .imiss_valid (imiss_valid),
        .imiss_page  (imiss_page),
        .dmiss_valid (dmiss_valid),
        .dmiss_page  (dmiss_page),
        .q           (q)
    );

    twa_addr_calc u_calc (
        .mode_4k   (walk_4k_mode),
        .l1_base_q (q[SLOT_L1B]),
        .ctrl_q    (q[SLOT_CTL]),
        .dpage     (q[SLOT_DPG][DATA_W-1:PAGE_LSB]),
        .l1_addr   (l1_addr),
        .ctrl_rd   (ctrl_rd)
    );

    // read view per slot: plain contents or computed address
    always_comb begin
        view           = q;
        view[SLOT_L1B] = l1_addr;
        view[SLOT_CTL] = ctrl_rd;
    end

    twa_rdmux u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .re    (reg_re),
        .sel   (sel),
        .view  (view),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/twa_checker.sv
// Port-level temporal checks for twa_regfile, bound to every instance.
// Assumes the default register numbers are passed through from the bound instance.
module twa_checker #(
    parameter int REGNUM_W = 10,
    parameter int NUM_IPG  = 787,
    parameter int NUM_DPG  = 795,
    parameter int NUM_L1B  = 796,
    parameter int NUM_CTL  = 797,
    parameter int NUM_SCR  = 799
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic                reg_re,
    input logic [REGNUM_W-1:0] reg_num,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic                walk_4k_mode
);
    logic known;
    assign known = (reg_num == REGNUM_W'(NUM_IPG)) || (reg_num == REGNUM_W'(NUM_DPG)) ||
                   (reg_num == REGNUM_W'(NUM_L1B)) || (reg_num == REGNUM_W'(NUM_CTL)) ||
                   (reg_num == REGNUM_W'(NUM_SCR));

    // R1: reset clears the read port
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> reg_rdata == 32'd0);

    // R2: no read strobe, no change on the read port
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));

    // R3: reserved bits of page registers read as zero
    assert_page_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re && (reg_num == REGNUM_W'(NUM_IPG) || reg_num == REGNUM_W'(NUM_DPG))
        |=> (reg_rdata & ~32'hFFFF_F20F) == 32'd0);

    // R5: descriptor address is word aligned
    assert_l1_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re && reg_num == REGNUM_W'(NUM_L1B) |=> reg_rdata[1:0] == 2'b00);

    // R6: entry address is word aligned in assist mode
    assert_l2_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re && walk_4k_mode && reg_num == REGNUM_W'(NUM_CTL) |=> reg_rdata[1:0] == 2'b00);

    // R7: raw control read keeps bits 11:9 clear
    assert_ctrl_rsvd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re && !walk_4k_mode && reg_num == REGNUM_W'(NUM_CTL) |=> reg_rdata[11:9] == 3'b000);

    // R8: scratch write followed by a lone read returns the written word
    assert_scratch_rw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) && $past(rst_n) &&
        $past(reg_we && reg_num == REGNUM_W'(NUM_SCR), 2) && !$past(reg_we) &&
        $past(reg_re && reg_num == REGNUM_W'(NUM_SCR))
        |-> reg_rdata == $past(reg_wdata, 2));

    // R9: unused numbers read as zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re && !known |=> reg_rdata == 32'd0);
endmodule

bind twa_regfile twa_checker #(
    .REGNUM_W (REGNUM_W),
    .NUM_IPG  (NUM_IPG),
    .NUM_DPG  (NUM_DPG),
    .NUM_L1B  (NUM_L1B),
    .NUM_CTL  (NUM_CTL),
    .NUM_SCR  (NUM_SCR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .reg_num      (reg_num),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .walk_4k_mode (walk_4k_mode)
);

// File: tb/tb_twa_regfile.sv
module tb_twa_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [9:0]  reg_num = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        walk_4k_mode = 1'b1;
    logic        imiss_valid = 1'b0;
    logic [19:0] imiss_page = '0;
    logic        dmiss_valid = 1'b0;
    logic [19:0] dmiss_page = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit pend  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // bench-side model of stored contents
    logic [31:0] m_ipg, m_dpg, m_l1b, m_ctl, m_scr;

    always #4 clk = ~clk;   // 125 MHz

    twa_regfile dut (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_re (reg_re),
        .reg_num (reg_num), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .walk_4k_mode (walk_4k_mode), .imiss_valid (imiss_valid),
        .imiss_page (imiss_page), .dmiss_valid (dmiss_valid), .dmiss_page (dmiss_page)
    );

    task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: a read issued at an edge is checked at the following falling edge
    always @(posedge clk) pend <= reg_re && rst_n;
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) compare(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic wr(input int num, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_num = 10'(num); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int num, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_re = 1'b1; reg_num = 10'(num);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic rdwr(input int num, input logic [31:0] d, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        reg_re = 1'b1; reg_we = 1'b1; reg_num = 10'(num); reg_wdata = d;
        @(negedge clk);
        reg_re = 1'b0; reg_we = 1'b0;
    endtask

    task automatic dmiss(input logic [19:0] p);
        @(negedge clk);
        dmiss_valid = 1'b1; dmiss_page = p;
        @(negedge clk);
        dmiss_valid = 1'b0;
        m_dpg = {p, m_dpg[11:0]};
    endtask

    function automatic logic [31:0] l1_exp();
        return {m_l1b[31:12], m_dpg[31:22], 2'b00};
    endfunction
    function automatic logic [31:0] l2_exp();
        return {m_ctl[31:12], m_dpg[21:12], 2'b00};
    endfunction

    task automatic read_all(input string tag);
        rd(787, m_ipg, tag);
        rd(795, m_dpg, tag);
        rd(796, l1_exp(), tag);
        rd(797, walk_4k_mode ? l2_exp() : m_ctl, tag);
        rd(799, m_scr, tag);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog R2: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_ipg = '0; m_dpg = '0; m_l1b = '0; m_ctl = '0; m_scr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(reg_rdata, 32'd0, "R1 rdata after reset");
        read_all("R1 reset contents");

        // R8 scratch
        wr(799, 32'hDEAD_BEEF); m_scr = 32'hDEAD_BEEF;
        rd(799, m_scr, "R8 scratch a");
        wr(799, 32'h1234_5678); m_scr = 32'h1234_5678;
        rd(799, m_scr, "R8 scratch b");

        // R3 page register masks
        wr(795, 32'hFFFF_FFFF); m_dpg = 32'hFFFF_F20F;
        rd(795, m_dpg, "R3 data page mask");
        wr(787, 32'hABCD_E3A5); m_ipg = 32'hABCD_E205;
        rd(787, m_ipg, "R3 instr page mask");

        // R4 miss capture keeps low bits
        dmiss(20'h12345);
        rd(795, m_dpg, "R4 data miss");
        @(negedge clk); imiss_valid = 1'b1; imiss_page = 20'h0BEEF;
        @(negedge clk); imiss_valid = 1'b0; m_ipg = {20'h0BEEF, m_ipg[11:0]};
        rd(787, m_ipg, "R4 instr miss");

        // R5 first-level address
        wr(796, 32'hCAFE_0FFF); m_l1b = 32'hCAFE_0000;
        rd(796, l1_exp(), "R5 l1 address");

        // R6 / R7 control register in both modes
        wr(797, 32'h5A5A_5FFF); m_ctl = 32'h5A5A_51FF;
        rd(797, l2_exp(), "R6 entry address");
        walk_4k_mode = 1'b0;
        rd(797, m_ctl, "R7 raw control");
        walk_4k_mode = 1'b1;

        // R11 computed reads follow a new miss
        dmiss(20'hFFC01);
        rd(796, l1_exp(), "R11 l1 after miss");
        rd(797, l2_exp(), "R11 l2 after miss");
        dmiss(20'h003FF);
        rd(796, l1_exp(), "R11 l1 low page");
        rd(797, l2_exp(), "R11 l2 low page");

        // R9 unused numbers
        wr(798, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        wr(1023, 32'hFFFF_FFFF);
        rd(798, 32'd0, "R9 unused 798");
        rd(0, 32'd0, "R9 unused 0");
        rd(1023, 32'd0, "R9 unused 1023");
        read_all("R9 contents untouched");

        // R10 read and write together
        rdwr(799, 32'h0F0F_1234, m_scr, "R10 old value");
        m_scr = 32'h0F0F_1234;
        rd(799, m_scr, "R10 new value");

        // R4 miss beats same-cycle write
        @(negedge clk);
        reg_we = 1'b1; reg_num = 10'd795; reg_wdata = 32'h0000_000A;
        dmiss_valid = 1'b1; dmiss_page = 20'h00077;
        @(negedge clk);
        reg_we = 1'b0; dmiss_valid = 1'b0;
        m_dpg = {20'h00077, m_dpg[11:0]};
        rd(795, m_dpg, "R4 miss beats write");

        // R2 hold without read strobe
        rd(799, m_scr, "R2 read");
        repeat (3) begin
            @(negedge clk);
            compare(reg_rdata, m_scr, "R2 hold");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule